// File: doc/BRIEF.md
# Rotated Frame-Buffer Scan Parameter Calculator

This block turns a description of a frame buffer and a display orientation into the six numbers a double-indexed scan engine needs: the first and last byte address of the scan, the element count per line, the number of lines, and the signed element and frame steps. Software or a setup sequencer drives the geometry on the inputs, pulses `start`, and waits for `done`. The geometry covers the base address, visible width and height, virtual line width, horizontal and vertical scale factors, element size, one of four rotations and a mirror flag.

Each pixel (x, y) lives at `base + (y*vw*ys + x*xs)*es`. Here vw is the virtual line width, xs and ys are the scale factors and es is the element size in bytes. A step from one pixel to another is encoded as the address difference minus es plus one. The block computes the two strides with one shared iterative shift-add multiplier. It then picks start and end corners and step pairs for the eight orientation and mirror cases. All results are committed together.

Top module: `scan_param_calc`

## Requirements
- R1: After reset `busy`, `done` and `err` are low, and every result output is zero.
- R2: For a valid request, `topAddr`, `botAddr`, `elemIdx` and `frameIdx` follow the pixel address `base + (y*vw*ys + x*xs)*es` and the step encoding `addr(dst) - addr(src) - es + 1`. Both are taken modulo 2^AW, with the steps in two's complement. `esCode` 0, 1 and 2 select es = 1, 2 and 4 bytes.
- R3: `rotCode` 0, 1, 2 and 3 select 0, 90, 180 and 270 degrees. For 0 and 180, `elemCnt` = xres and `frameCnt` = yres. For 90 and 270 the two counts are swapped.
- R4: With mirror low, the scan runs between these corners. At 0 degrees it goes from (0,0) to (xres-1,yres-1), element step (0,0)->(1,0), frame step (xres-1,0)->(0,1). At 90 it goes from (0,yres-1) to (xres-1,0), element step (0,1)->(0,0), frame step (0,0)->(1,yres-1). At 180 it goes from (xres-1,yres-1) to (0,0), element step (1,0)->(0,0), frame step (0,1)->(xres-1,0). At 270 it goes from (xres-1,0) to (0,yres-1), element step (0,0)->(0,1), frame step (1,yres-1)->(0,0).
- R5: With mirror high, the horizontal direction is reversed. At 0 degrees the scan goes from (xres-1,0) to (0,yres-1), element step (1,0)->(0,0), frame step (0,0)->(xres-1,1). At 90 it goes from (xres-1,yres-1) to (0,0), element step (0,1)->(0,0), frame step (1,0)->(0,yres-1). At 180 it goes from (0,yres-1) to (xres-1,0), element step (0,0)->(1,0), frame step (xres-1,1)->(0,0). At 270 it goes from (0,0) to (xres-1,yres-1), element step (0,0)->(0,1), frame step (0,yres-1)->(1,0).
- R6: A virtual width of zero acts as xres, and a scale factor of zero acts as one.
- R7: `dblIdx` is high exactly when the request had a non-zero rotation, mirror set, a non-zero virtual width or a non-zero scale. Otherwise the index outputs are marked unused by `dblIdx` low.
- R8: A `start` with `rotCode` above 3, with `esCode` equal to 3, or with a non-zero virtual width below xres raises `err` and leaves `done` low one cycle later. All result outputs keep their previous values.
- R9: After a valid `start`, `busy` stays high until the results are committed. At that point `done` rises and stays high until the next accepted `start`. A `start` while `busy` is high is ignored.
- R10: The result outputs change only in the cycle that `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled when idle |
| baseAddr | input | AW | Frame-buffer base byte address |
| xres | input | DW | Visible width in pixels |
| yres | input | DW | Visible height in lines |
| vxres | input | DW | Virtual line width, 0 = xres |
| xscale | input | SW | Horizontal scale, 0 = 1 |
| yscale | input | SW | Vertical scale, 0 = 1 |
| esCode | input | 2 | Element size: 0=1, 1=2, 2=4 bytes, 3 invalid |
| rotCode | input | 3 | Rotation: 0..3 = 0/90/180/270, 4..7 invalid |
| mirror | input | 1 | Reverse horizontal direction |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Results valid |
| err | output | 1 | Last request rejected |
| topAddr | output | AW | First scan address |
| botAddr | output | AW | Last scan address |
| elemCnt | output | DW | Elements per frame line |
| frameCnt | output | DW | Frame lines |
| elemIdx | output | AW | Signed element step |
| frameIdx | output | AW | Signed frame step |
| dblIdx | output | 1 | Double-indexed scan required |

## Verification
The hardest situation to reach is a request that arrives while the multiplier is partway through its three products. If the inputs leaked past the latch, only the later strides would be corrupted. The bench starts a long scaled request, then after a few cycles drives a different geometry with a second `start` pulse and leaves it on the pins. The committed results must still match the first request. Rejected requests are issued straight after a valid result, so that held outputs can be told apart from reset values.

// File: rtl/scan_param_pkg.sv
package scan_param_pkg;

  typedef enum logic [1:0] {
    SEL_LINE = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2
  } mulSelT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GO1, ST_RUN1, ST_GO2, ST_RUN2, ST_GO3, ST_RUN3, ST_FIN
  } ctrlStateT;

  typedef struct packed {
    logic   latch;
    logic   mulGo;
    mulSelT mulSel;
    logic   capture;
    logic   commit;
  } strobeT;

endpackage

// File: rtl/scan_param_mul.sv
module scan_param_mul #(
  parameter int AW = 32,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          go,
  input  logic [AW-1:0] opA,
  input  logic [DW-1:0] opB,
  output logic          rdy,
  output logic [AW-1:0] prod
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [AW-1:0] aSh;
  logic [DW-1:0] bSh;
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aSh <= '0; bSh <= '0; cnt <= '0; run <= 1'b0; rdy <= 1'b0; prod <= '0;
    end else if (go) begin
      aSh <= opA; bSh <= opB; cnt <= '0; run <= 1'b1; rdy <= 1'b0; prod <= '0;
    end else if (run) begin
      if (bSh[0]) prod <= prod + aSh;
      aSh <= aSh << 1;
      bSh <= bSh >> 1;
      cnt <= cnt + 1'b1;
      if (cnt == CW'(DW - 1)) begin
        run <= 1'b0;
        rdy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_param_ctrl.sv
module scan_param_ctrl
  import scan_param_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   cfgBad,
  input  logic   mulRdy,
  output strobeT stb,
  output logic   busy,
  output logic   done,
  output logic   err
);
  ctrlStateT state, nextState;

  always_comb begin
    stb = '0;
    stb.mulSel = SEL_LINE;
    nextState = state;
    unique case (state)
      ST_IDLE: if (start && !cfgBad) begin
        stb.latch = 1'b1;
        nextState = ST_GO1;
      end
      ST_GO1:  begin stb.mulGo = 1'b1; nextState = ST_RUN1; end
      ST_RUN1: if (mulRdy) begin stb.capture = 1'b1; nextState = ST_GO2; end
      ST_GO2:  begin stb.mulGo = 1'b1; stb.mulSel = SEL_A; nextState = ST_RUN2; end
      ST_RUN2: begin
        stb.mulSel = SEL_A;
        if (mulRdy) begin stb.capture = 1'b1; nextState = ST_GO3; end
      end
      ST_GO3:  begin stb.mulGo = 1'b1; stb.mulSel = SEL_B; nextState = ST_RUN3; end
      ST_RUN3: begin
        stb.mulSel = SEL_B;
        if (mulRdy) begin stb.capture = 1'b1; nextState = ST_FIN; end
      end
      ST_FIN:  begin stb.commit = 1'b1; nextState = ST_IDLE; end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; done <= 1'b0; err <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        done <= 1'b0;
        err  <= cfgBad;
      end else if (state == ST_FIN) begin
        done <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/scan_param_dp.sv
module scan_param_dp
  import scan_param_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 12,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  input  logic [AW-1:0] baseAddr,
  input  logic [DW-1:0] xres,
  input  logic [DW-1:0] yres,
  input  logic [DW-1:0] vxres,
  input  logic [SW-1:0] xscale,
  input  logic [SW-1:0] yscale,
  input  logic [1:0]    esCode,
  input  logic [2:0]    rotCode,
  input  logic          mirror,
  output logic          cfgBad,
  output logic          mulRdy,
  output logic [AW-1:0] topAddr,
  output logic [AW-1:0] botAddr,
  output logic [DW-1:0] elemCnt,
  output logic [DW-1:0] frameCnt,
  output logic [AW-1:0] elemIdx,
  output logic [AW-1:0] frameIdx,
  output logic          dblIdx
);
  logic [AW-1:0] baseQ, lineQ, aQ, bQ, mulA, prod;
  logic [DW-1:0] xresQ, yresQ, vxQ, mulB;
  logic [SW-1:0] xsQ, ysQ;
  logic [1:0]    esShQ, rotQ;
  logic          mirQ, dblQ;
  logic [AW-1:0] colS, adj, topN, botN, eiN, fiN;

  assign cfgBad = (rotCode > 3'd3) || (esCode == 2'd3) ||
                  ((vxres != '0) && (vxres < xres));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; xresQ <= '0; yresQ <= '0; vxQ <= '0; xsQ <= '0; ysQ <= '0;
      esShQ <= '0; rotQ <= '0; mirQ <= 1'b0; dblQ <= 1'b0;
    end else if (stb.latch) begin
      baseQ <= baseAddr;
      xresQ <= xres;
      yresQ <= yres;
      vxQ   <= (vxres == '0) ? xres : vxres;
      xsQ   <= (xscale == '0) ? SW'(1) : xscale;
      ysQ   <= (yscale == '0) ? SW'(1) : yscale;
      esShQ <= esCode;
      rotQ  <= rotCode[1:0];
      mirQ  <= mirror;
      dblQ  <= (rotCode != 3'd0) || mirror || (vxres != '0) ||
               (xscale != '0) || (yscale != '0);
    end
  end

  assign colS = AW'(xsQ) << esShQ;

  always_comb begin
    unique case (stb.mulSel)
      SEL_A:   begin mulA = colS;    mulB = xresQ - 1'b1; end
      SEL_B:   begin mulA = lineQ;   mulB = yresQ - 1'b1; end
      default: begin mulA = AW'(vxQ); mulB = DW'(ysQ);   end
    endcase
  end

  scan_param_mul #(.AW(AW), .DW(DW)) uMul (
    .clk(clk), .rstN(rstN), .go(stb.mulGo), .opA(mulA), .opB(mulB),
    .rdy(mulRdy), .prod(prod)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ <= '0; aQ <= '0; bQ <= '0;
    end else if (stb.capture) begin
      unique case (stb.mulSel)
        SEL_A:   aQ <= prod;
        SEL_B:   bQ <= prod;
        default: lineQ <= prod << esShQ;
      endcase
    end
  end

  // Step bias: 1 - es
  assign adj = AW'(1) - (AW'(1) << esShQ);

  always_comb begin
    unique case ({rotQ, mirQ})
      3'b000: begin topN = baseQ;           botN = baseQ + aQ + bQ;
                    eiN = colS + adj;        fiN = lineQ - aQ + adj; end
      3'b001: begin topN = baseQ + aQ;      botN = baseQ + bQ;
                    eiN = adj - colS;        fiN = aQ + lineQ + adj; end
      3'b010: begin topN = baseQ + bQ;      botN = baseQ + aQ;
                    eiN = adj - lineQ;       fiN = colS + bQ + adj; end
      3'b011: begin topN = baseQ + aQ + bQ; botN = baseQ;
                    eiN = adj - lineQ;       fiN = bQ - colS + adj; end
      3'b100: begin topN = baseQ + aQ + bQ; botN = baseQ;
                    eiN = adj - colS;        fiN = aQ - lineQ + adj; end
      3'b101: begin topN = baseQ + bQ;      botN = baseQ + aQ;
                    eiN = colS + adj;        fiN = adj - aQ - lineQ; end
      3'b110: begin topN = baseQ + aQ;      botN = baseQ + bQ;
                    eiN = lineQ + adj;       fiN = adj - colS - bQ; end
      default: begin topN = baseQ;          botN = baseQ + aQ + bQ;
                    eiN = lineQ + adj;       fiN = colS - bQ + adj; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topAddr <= '0; botAddr <= '0; elemCnt <= '0; frameCnt <= '0;
      elemIdx <= '0; frameIdx <= '0; dblIdx <= 1'b0;
    end else if (stb.commit) begin
      topAddr  <= topN;
      botAddr  <= botN;
      elemCnt  <= rotQ[0] ? yresQ : xresQ;
      frameCnt <= rotQ[0] ? xresQ : yresQ;
      elemIdx  <= eiN;
      frameIdx <= fiN;
      dblIdx   <= dblQ;
    end
  end
endmodule

// File: rtl/scan_param_calc.sv
module scan_param_calc
  import scan_param_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 12,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] baseAddr,
  input  logic [DW-1:0] xres,
  input  logic [DW-1:0] yres,
  input  logic [DW-1:0] vxres,
  input  logic [SW-1:0] xscale,
  input  logic [SW-1:0] yscale,
  input  logic [1:0]    esCode,
  input  logic [2:0]    rotCode,
  input  logic          mirror,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] topAddr,
  output logic [AW-1:0] botAddr,
  output logic [DW-1:0] elemCnt,
  output logic [DW-1:0] frameCnt,
  output logic [AW-1:0] elemIdx,
  output logic [AW-1:0] frameIdx,
  output logic          dblIdx
);
  strobeT stb;
  logic   cfgBad, mulRdy;

  scan_param_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgBad(cfgBad), .mulRdy(mulRdy),
    .stb(stb), .busy(busy), .done(done), .err(err)
  );

  scan_param_dp #(.AW(AW), .DW(DW), .SW(SW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .baseAddr(baseAddr), .xres(xres), .yres(yres), .vxres(vxres),
    .xscale(xscale), .yscale(yscale), .esCode(esCode), .rotCode(rotCode),
    .mirror(mirror), .cfgBad(cfgBad), .mulRdy(mulRdy),
    .topAddr(topAddr), .botAddr(botAddr), .elemCnt(elemCnt),
    .frameCnt(frameCnt), .elemIdx(elemIdx), .frameIdx(frameIdx),
    .dblIdx(dblIdx)
  );
endmodule

// File: rtl/scan_param_chk.sv
module scan_param_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [2:0]    rotCode,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [AW-1:0] topAddr,
  input logic [AW-1:0] frameIdx
);
  // R8: done and err never together
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  // R9: results are not flagged valid while still computing
  p_busy_not_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  // R10: results only move when done rises
  p_hold_top_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(done) |-> $stable(topAddr));

  p_hold_fidx_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(done) |-> $stable(frameIdx));

  // R8: a bad rotation code accepted while idle raises err
  p_bad_rot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && rotCode > 3'd3) |=> (err && !done && !busy));
endmodule

bind scan_param_calc scan_param_chk #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .rotCode(rotCode), .busy(busy),
  .done(done), .err(err), .topAddr(topAddr), .frameIdx(frameIdx)
);

// File: tb/test_scan_param_calc.sv
module test_scan_param_calc;
  localparam int AW = 32;
  localparam int DW = 12;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [DW-1:0] xres = '0, yres = '0, vxres = '0;
  logic [SW-1:0] xscale = '0, yscale = '0;
  logic [1:0]    esCode = '0;
  logic [2:0]    rotCode = '0;
  logic          mirror = 1'b0;
  logic          busy, done, err, dblIdx;
  logic [AW-1:0] topAddr, botAddr, elemIdx, frameIdx;
  logic [DW-1:0] elemCnt, frameCnt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scan_param_calc #(.AW(AW), .DW(DW), .SW(SW)) i_scan_param_calc (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .xres(xres),
    .yres(yres), .vxres(vxres), .xscale(xscale), .yscale(yscale),
    .esCode(esCode), .rotCode(rotCode), .mirror(mirror), .busy(busy),
    .done(done), .err(err), .topAddr(topAddr), .botAddr(botAddr),
    .elemCnt(elemCnt), .frameCnt(frameCnt), .elemIdx(elemIdx),
    .frameIdx(frameIdx), .dblIdx(dblIdx)
  );

  // expected model state
  logic [AW-1:0] eTop, eBot, eEi, eFi;
  logic [DW-1:0] eEc, eFc;
  logic          eDbl;
  longint mB, mVx, mXs, mYs, mEs;

  function automatic longint pix(longint x, longint y);
    return mB + (y * mVx * mYs + x * mXs) * mEs;
  endfunction

  function automatic logic [AW-1:0] step(longint sx, longint sy, longint dx, longint dy);
    return AW'(pix(dx, dy) - pix(sx, sy) - mEs + 1);
  endfunction

  task automatic model(input logic [AW-1:0] b, input int xr, input int yr,
                       input int vx, input int xs, input int ys, input int es,
                       input int rot, input bit mir);
    longint X, Y;
    X = xr - 1; Y = yr - 1;
    mB = b; mVx = (vx == 0) ? xr : vx;
    mXs = (xs == 0) ? 1 : xs; mYs = (ys == 0) ? 1 : ys;
    mEs = (es == 0) ? 1 : (es == 1) ? 2 : 4;
    eEc = DW'((rot % 2) ? yr : xr);
    eFc = DW'((rot % 2) ? xr : yr);
    eDbl = (rot != 0) || mir || (vx != 0) || (xs != 0) || (ys != 0);
    case ({rot[1:0], mir})
      3'b000: begin eTop = AW'(pix(0,0)); eBot = AW'(pix(X,Y));
                    eEi = step(0,0,1,0); eFi = step(X,0,0,1); end
      3'b001: begin eTop = AW'(pix(X,0)); eBot = AW'(pix(0,Y));
                    eEi = step(1,0,0,0); eFi = step(0,0,X,1); end
      3'b010: begin eTop = AW'(pix(0,Y)); eBot = AW'(pix(X,0));
                    eEi = step(0,1,0,0); eFi = step(0,0,1,Y); end
      3'b011: begin eTop = AW'(pix(X,Y)); eBot = AW'(pix(0,0));
                    eEi = step(0,1,0,0); eFi = step(1,0,0,Y); end
      3'b100: begin eTop = AW'(pix(X,Y)); eBot = AW'(pix(0,0));
                    eEi = step(1,0,0,0); eFi = step(0,1,X,0); end
      3'b101: begin eTop = AW'(pix(0,Y)); eBot = AW'(pix(X,0));
                    eEi = step(0,0,1,0); eFi = step(X,1,0,0); end
      3'b110: begin eTop = AW'(pix(X,0)); eBot = AW'(pix(0,Y));
                    eEi = step(0,0,0,1); eFi = step(1,Y,0,0); end
      default: begin eTop = AW'(pix(0,0)); eBot = AW'(pix(X,Y));
                    eEi = step(0,0,0,1); eFi = step(0,Y,1,0); end
    endcase
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] b, input int xr, input int yr,
                       input int vx, input int xs, input int ys, input int es,
                       input int rot, input bit mir);
    baseAddr = b; xres = DW'(xr); yres = DW'(yr); vxres = DW'(vx);
    xscale = SW'(xs); yscale = SW'(ys); esCode = 2'(es); rotCode = 3'(rot);
    mirror = mir;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic check_all(input string req);
    chk(req, "done", done, 1);
    chk(req, "err", err, 0);
    chk(req, "topAddr", topAddr, eTop);
    chk(req, "botAddr", botAddr, eBot);
    chk(req, "elemCnt", elemCnt, eEc);
    chk(req, "frameCnt", frameCnt, eFc);
    chk(req, "elemIdx", elemIdx, eEi);
    chk(req, "frameIdx", frameIdx, eFi);
    chk(req, "dblIdx", dblIdx, eDbl);
  endtask

  task automatic run_case(input string req, input logic [AW-1:0] b, input int xr,
                          input int yr, input int vx, input int xs, input int ys,
                          input int es, input int rot, input bit mir);
    drive(b, xr, yr, vx, xs, ys, es, rot, mir);
    model(b, xr, yr, vx, xs, ys, es, rot, mir);
    pulse_start();
    chk(req, "busy after start", busy, 1);
    wait_idle();
    check_all(req);
  endtask

  task automatic test_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    chk("R1", "topAddr", topAddr, 0);
    chk("R1", "frameIdx", frameIdx, 0);
    chk("R1", "dblIdx", dblIdx, 0);
  endtask

  task automatic test_rotations();
    // R2 R3 R4: non-mirrored, with scaling and virtual width
    for (int r = 0; r < 4; r++)
      run_case("R4", 32'h1000_0000, 320, 240, 400, 2, 3, 1, r, 1'b0);
    // R5: mirrored
    for (int r = 0; r < 4; r++)
      run_case("R5", 32'h2000_0400, 176, 144, 200, 1, 2, 2, r, 1'b1);
    // R2: byte elements, odd sizes
    run_case("R2", 32'h0000_0010, 7, 5, 9, 3, 1, 0, 1, 1'b0);
  endtask

  task automatic test_defaults();
    // R6 R7: plain case, no double indexing
    run_case("R7", 32'h8000_0000, 640, 480, 0, 0, 0, 1, 0, 1'b0);
    // R6: zero virtual width and scale with rotation
    run_case("R6", 32'h0004_0000, 100, 60, 0, 0, 0, 2, 3, 1'b0);
    // R7: only vertical scale set
    run_case("R7", 32'h0000_0100, 16, 8, 0, 0, 2, 0, 0, 1'b0);
  endtask

  task automatic test_errors();
    logic [AW-1:0] hTop, hFi;
    run_case("R8", 32'h3000_0000, 50, 40, 64, 1, 1, 1, 2, 1'b1);
    hTop = eTop; hFi = eFi;
    drive(32'h1234_5678, 20, 10, 0, 0, 0, 1, 5, 1'b0);
    pulse_start();
    chk("R8", "err bad rot", err, 1);
    chk("R8", "done bad rot", done, 0);
    chk("R8", "topAddr held", topAddr, hTop);
    chk("R8", "frameIdx held", frameIdx, hFi);
    drive(32'h1234_5678, 20, 10, 0, 0, 0, 3, 0, 1'b0);
    pulse_start();
    chk("R8", "err bad es", err, 1);
    chk("R8", "topAddr held es", topAddr, hTop);
    drive(32'h1234_5678, 20, 10, 19, 0, 0, 0, 0, 1'b0);
    pulse_start();
    chk("R8", "err narrow vxres", err, 1);
    chk("R8", "busy narrow vxres", busy, 0);
    chk("R8", "frameIdx held vx", frameIdx, hFi);
  endtask

  task automatic test_busy_start();
    drive(32'h4000_0000, 1024, 768, 2048, 15, 15, 2, 1, 1'b1);
    model(32'h4000_0000, 1024, 768, 2048, 15, 15, 2, 1, 1'b1);
    pulse_start();
    repeat (4) @(negedge clk);
    chk("R9", "done low while busy", done, 0);
    drive(32'h0000_0000, 8, 8, 0, 0, 0, 0, 0, 1'b0);
    pulse_start();
    chk("R9", "still busy", busy, 1);
    wait_idle();
    check_all("R9");
    repeat (3) @(negedge clk);
    chk("R9", "done holds", done, 1);
    chk("R10", "topAddr stable", topAddr, eTop);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_rotations();
    test_defaults();
    test_errors();
    test_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule